// File: doc/BRIEF.md
# ECC Error Status Trap Logic

This block sits beside a memory's on-die single-correct/double-detect ECC and turns its per-read error flags into status that a host can read back. Each read the decoder completes arrives as a one-cycle strobe with two flags: one for a corrected single-bit error and one for an uncorrectable double-bit error. The byte address of the access comes with the strobe. ECC works on 8-byte data units, so the block reduces the byte address to a unit address by discarding its three low bits.

Three pieces of state are kept and shown on parallel ports. The first is an 8-bit status byte whose bit 0 flags a double-bit detection. The second is an address trap that holds the unit address of the first double-bit failure and never overwrites it. The third is a saturating count of every double-bit detection. A host command with opcode 0x1B clears only the status flag. A hardware reset, a software reset pulse or a low-power-exit pulse clears all of the state.

Top module: `ecc_err_trap`

## Requirements
- R1: While `rst_n` is low, `stat_q`, `trap_vld`, `trap_addr` and `dbe_cnt` are all zero.
- R2: A cycle with `rd_evt` and `dbe_flag` both high sets `stat_q[0]` on the next edge. Bits 7:1 of `stat_q` always read zero.
- R3: A cycle with `cmd_stb` high and `cmd_op` equal to 0x1B clears `stat_q[0]` and leaves the trap and the count unchanged. Any other opcode has no effect.
- R4: If a double-bit event and a clear command come in the same cycle, `stat_q[0]` is 1 after the edge.
- R5: The first double-bit event after any reset sets `trap_vld` and loads `trap_addr` with `byte_addr[ADDR_W-1:3]`.
- R6: While `trap_vld` is set, later double-bit events leave `trap_addr` unchanged.
- R7: Each double-bit event adds exactly one to `dbe_cnt`.
- R8: `dbe_cnt` holds at all ones and does not wrap.
- R9: A cycle with `sw_reset` or `lp_exit` high clears `stat_q[0]`, `trap_vld`, `trap_addr` and `dbe_cnt` on the next edge. This takes priority over a double-bit event in the same cycle.
- R10: A single-bit corrected event, and a `dbe_flag` without `rd_evt`, change no output.
- R11: With no event, command or reset, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware / power-on reset |
| sw_reset | input | 1 | Software reset pulse, synchronous |
| lp_exit | input | 1 | Low-power-mode exit pulse, synchronous |
| rd_evt | input | 1 | Read-completed strobe from the ECC decoder |
| sbe_flag | input | 1 | Single-bit error corrected on this read |
| dbe_flag | input | 1 | Double-bit error detected on this read |
| byte_addr | input | ADDR_W | Byte address of the read |
| cmd_stb | input | 1 | Host command valid |
| cmd_op | input | 8 | Host command opcode |
| stat_q | output | 8 | ECC status byte; bit 0 = double-bit detected |
| trap_vld | output | 1 | Address trap holds an address |
| trap_addr | output | ADDR_W-3 | First failing unit address |
| dbe_cnt | output | CNT_W | Saturating double-bit detection count |

## Verification
The bench builds the block with `CNT_W = 4` and `ADDR_W = 12`. The narrow counter reaches all ones after fifteen events, so the saturation rule can be checked within a short run. The 9-bit unit address is still wide enough that a wrong shift, or a dropped upper bit in the trap, shows up as a mismatch. A reference model in the bench tracks every cycle, including the cases where a clear collides with an event and where a reset collides with an event.

// File: rtl/ecc_trap_pkg.sv
package ecc_trap_pkg;
  localparam logic [7:0] OP_CLR_STAT  = 8'h1B;
  localparam int         STAT_W       = 8;
  localparam int         STAT_DBE_BIT = 0;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SBE  = 2'd1,
    EV_DBE  = 2'd2
  } ecc_ev_e;
endpackage

// File: rtl/ecc_evt_decode.sv
module ecc_evt_decode
  import ecc_trap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 3,
  localparam int UNIT_W = ADDR_W - OFS_W
) (
  input  logic              rd_evt,
  input  logic              sbe_flag,
  input  logic              dbe_flag,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_op,
  output ecc_ev_e           ev_kind,
  output logic              dbe_evt,
  output logic              clr_req,
  output logic [UNIT_W-1:0] unit_addr
);
  function automatic logic [UNIT_W-1:0] to_unit(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] sh;
    sh = a >> OFS_W;
    return sh[UNIT_W-1:0];
  endfunction

  always_comb begin
    if (!rd_evt)        ev_kind = EV_NONE;
    else if (dbe_flag)  ev_kind = EV_DBE;
    else if (sbe_flag)  ev_kind = EV_SBE;
    else                ev_kind = EV_NONE;
  end

  assign dbe_evt   = (ev_kind == EV_DBE);
  assign clr_req   = cmd_stb && (cmd_op == OP_CLR_STAT);
  assign unit_addr = to_unit(byte_addr);
endmodule

// File: rtl/ecc_stat_reg.sv
module ecc_stat_reg
  import ecc_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              dbe_evt,
  input  logic              clr_req,
  output logic [STAT_W-1:0] stat_q
);
  logic dbe_flag_q;

  function automatic logic next_flag(input logic cur, input logic ev, input logic clr);
    if (ev)       return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dbe_flag_q <= 1'b0;
    else if (clr_all) dbe_flag_q <= 1'b0;
    else              dbe_flag_q <= next_flag(dbe_flag_q, dbe_evt, clr_req);
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bits
    if (b == STAT_DBE_BIT) begin : g_dbe
      assign stat_q[b] = dbe_flag_q;
    end else begin : g_zero
      assign stat_q[b] = 1'b0;
    end
  end

  // R2
  dbe_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbe_evt && !clr_all |=> stat_q[STAT_DBE_BIT]);
  // R3
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !dbe_evt && !clr_all |=> !stat_q[STAT_DBE_BIT]);
  // R4
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && dbe_evt && !clr_all |=> stat_q[STAT_DBE_BIT]);
endmodule

// File: rtl/ecc_addr_trap.sv
module ecc_addr_trap #(
  parameter int UNIT_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              dbe_evt,
  input  logic [UNIT_W-1:0] unit_addr,
  output logic              trap_vld,
  output logic [UNIT_W-1:0] trap_addr
);
  logic capture;
  assign capture = dbe_evt && !trap_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_vld  <= 1'b0;
      trap_addr <= '0;
    end else if (clr_all) begin
      trap_vld  <= 1'b0;
      trap_addr <= '0;
    end else if (capture) begin
      trap_vld  <= 1'b1;
      trap_addr <= unit_addr;
    end
  end

  // R5
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbe_evt && !trap_vld && !clr_all |=> trap_vld && (trap_addr == $past(unit_addr)));
  // R6
  trap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld && !clr_all |=> trap_vld && $stable(trap_addr));
endmodule

// File: rtl/ecc_dbe_counter.sv
module ecc_dbe_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             dbe_evt,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr_all) cnt <= '0;
    else if (dbe_evt) cnt <= sat_inc(cnt);
  end

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbe_evt && !clr_all && (cnt != CNT_MAX) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) && !clr_all |=> cnt == CNT_MAX);
endmodule

// File: rtl/ecc_err_trap.sv
module ecc_err_trap
  import ecc_trap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  localparam int OFS_W  = 3,
  localparam int UNIT_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              lp_exit,
  input  logic              rd_evt,
  input  logic              sbe_flag,
  input  logic              dbe_flag,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_op,
  output logic [7:0]        stat_q,
  output logic              trap_vld,
  output logic [UNIT_W-1:0] trap_addr,
  output logic [CNT_W-1:0]  dbe_cnt
);
  ecc_ev_e           ev_kind;
  logic              dbe_evt;
  logic              clr_req;
  logic              clr_all;
  logic [UNIT_W-1:0] unit_addr;

  assign clr_all = sw_reset || lp_exit;

  ecc_evt_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
    .rd_evt(rd_evt), .sbe_flag(sbe_flag), .dbe_flag(dbe_flag),
    .byte_addr(byte_addr), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .ev_kind(ev_kind), .dbe_evt(dbe_evt), .clr_req(clr_req),
    .unit_addr(unit_addr)
  );

  ecc_stat_reg u_stat (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .dbe_evt(dbe_evt), .clr_req(clr_req), .stat_q(stat_q)
  );

  ecc_addr_trap #(.UNIT_W(UNIT_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .dbe_evt(dbe_evt),
    .unit_addr(unit_addr), .trap_vld(trap_vld), .trap_addr(trap_addr)
  );

  ecc_dbe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .dbe_evt(dbe_evt), .cnt(dbe_cnt)
  );

  // R9
  reset_pulse_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (dbe_cnt == '0) && !trap_vld && (trap_addr == '0) && !stat_q[STAT_DBE_BIT]);
  // R10
  sbe_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_kind == EV_SBE) && !clr_all && !clr_req |=> $stable(stat_q) && $stable(dbe_cnt) && $stable(trap_addr));
  // R2
  upper_stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[7:1] == 7'd0);
endmodule

// File: tb/ecc_err_trap_tb.sv
module ecc_err_trap_tb;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;
  localparam int UNIT_W = ADDR_W - 3;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_reset = 1'b0, lp_exit = 1'b0;
  logic rd_evt = 1'b0, sbe_flag = 1'b0, dbe_flag = 1'b0;
  logic [ADDR_W-1:0] byte_addr = '0;
  logic cmd_stb = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [7:0] stat_q;
  logic trap_vld;
  logic [UNIT_W-1:0] trap_addr;
  logic [CNT_W-1:0] dbe_cnt;

  always #10 clk = ~clk;

  ecc_err_trap #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .lp_exit(lp_exit),
    .rd_evt(rd_evt), .sbe_flag(sbe_flag), .dbe_flag(dbe_flag),
    .byte_addr(byte_addr), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .stat_q(stat_q), .trap_vld(trap_vld), .trap_addr(trap_addr), .dbe_cnt(dbe_cnt)
  );

  typedef struct {
    logic [7:0]        stat;
    logic              tv;
    logic [UNIT_W-1:0] ta;
    logic [CNT_W-1:0]  cnt;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic              m_flag = 0, m_tv = 0;
  logic [UNIT_W-1:0] m_ta = '0;
  logic [CNT_W-1:0]  m_cnt = '0;

  task automatic compare(input exp_t e);
    n_chk++;
    if (stat_q !== e.stat || trap_vld !== e.tv || trap_addr !== e.ta || dbe_cnt !== e.cnt) begin
      n_fail++;
      $display("FAIL %s: got stat=%h vld=%b addr=%h cnt=%0d, expected stat=%h vld=%b addr=%h cnt=%0d",
               e.tag, stat_q, trap_vld, trap_addr, dbe_cnt, e.stat, e.tv, e.ta, e.cnt);
    end
  endtask

  function automatic exp_t snap(input string tag);
    exp_t e;
    e.stat = {7'd0, m_flag};
    e.tv = m_tv; e.ta = m_ta; e.cnt = m_cnt; e.tag = tag;
    return e;
  endfunction

  task automatic model_reset();
    m_flag = 0; m_tv = 0; m_ta = '0; m_cnt = '0;
  endtask

  // driver: one cycle of stimulus, model update, expected item queued
  task automatic step(input logic rd, input logic sb, input logic db,
                      input logic [ADDR_W-1:0] a, input logic cs,
                      input logic [7:0] op, input logic sw, input logic lp,
                      input string tag);
    logic dbe, clr;
    @(negedge clk);
    rd_evt = rd; sbe_flag = sb; dbe_flag = db; byte_addr = a;
    cmd_stb = cs; cmd_op = op; sw_reset = sw; lp_exit = lp;
    dbe = rd && db;
    clr = cs && (op == 8'h1B);
    if (sw || lp) model_reset();
    else begin
      if (dbe) m_flag = 1;
      else if (clr) m_flag = 0;
      if (dbe && !m_tv) begin m_tv = 1; m_ta = a[ADDR_W-1:3]; end
      if (dbe && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
    end
    @(posedge clk);
    #1;
    exp_q.push_back(snap(tag));
    rd_evt = 0; sbe_flag = 0; dbe_flag = 0; cmd_stb = 0; sw_reset = 0; lp_exit = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    #25;
    model_reset();
    compare(snap("R1 reset state"));
    @(negedge clk); rst_n = 1;
    step(0,0,0,'0,0,8'h00,0,0,"R11 idle hold");
    step(1,1,0,12'h123,0,8'h00,0,0,"R10 single-bit corrected ignored");
    step(0,0,1,12'h456,0,8'h00,0,0,"R10 dbe flag without strobe ignored");
    step(1,0,1,12'h2AB,0,8'h00,0,0,"R2 R5 R7 first double-bit event");
    step(0,0,0,'0,0,8'h00,0,0,"R11 hold after event");
    step(1,1,1,12'h7F0,0,8'h00,0,0,"R6 R7 second event keeps trap");
    step(0,0,0,'0,1,8'h1A,0,0,"R3 other opcode no effect");
    step(0,0,0,'0,1,8'h1B,0,0,"R3 clear keeps trap and count");
    step(1,0,1,12'hFFF,1,8'h1B,0,0,"R4 event beats clear");
    step(0,0,0,'0,1,8'h1B,0,0,"R3 clear again");
    for (int i = 0; i < 14; i++)
      step(1,0,1,ADDR_W'(i * 8),0,8'h00,0,0,"R7 R8 counting toward saturation");
    step(1,0,1,12'h008,0,8'h00,0,0,"R8 saturated count holds");
    step(0,0,0,'0,0,8'h00,1,0,"R9 software reset clears");
    step(1,0,1,12'h158,0,8'h00,0,0,"R5 capture after reset");
    step(1,0,1,12'h3C8,0,8'h00,0,1,"R9 low-power exit beats event");
    step(1,0,1,12'hA10,0,8'h00,0,0,"R5 recapture");
    step(0,0,0,'0,0,8'h00,0,1,"R9 low-power exit clears");
    step(1,0,1,12'h5E7,0,8'h00,0,0,"R5 capture before hw reset");
    @(negedge clk); rst_n = 0; model_reset();
    #2 compare(snap("R1 hardware reset mid-run"));
    @(negedge clk); rst_n = 1;
    step(0,0,0,'0,0,8'h00,0,0,"R11 idle after reset");
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule